// File: doc/BRIEF.md
# Gated Pulse-Rate Meter

This block measures how often a line-sync style pulse train arrives. One of two external sense inputs is synchronised and edge-detected. For a fixed gate window, the block counts the edges that match the chosen polarity. The window is one, two, four or eight base ticks long. A base tick is a nominal 1024 µs, taken from the system clock by a prescaler whose length is computed from a clock-frequency parameter.

When a window closes, the number of qualified edges seen in it goes into an 8-bit result register and counting starts again from zero. The result clamps at 255 when more edges arrive than fit in 8 bits. Software picks the input, the edge polarity and the window length through a small control register, and reads the most recent result from a second, read-only address.

Top module: `pulse_rate_meter`

## Requirements
- R1: After reset the control register reads 0x00, which selects input A, falling edges and the shortest window. The result register reads 0x00.
- R2: Address 0 is the control register: bit 0 picks the input (0 = sense_a, 1 = sense_b), bit 1 picks the polarity, and bits 4:3 pick the window. Bits 7:5 and 2 ignore writes and always read 0. Address 1 returns the result register. Reads are combinational on `addr`.
- R3: When a window holds more than 255 qualified edges, the result is 0xFF. The internal count holds at 0xFF and never wraps.
- R4: At the end of every window, the count of qualified edges seen in that window is copied to the result register. The count then restarts at zero, so each result depends only on its own window. Between window ends the result register does not change.
- R5: A window lasts BASE × 2^code clock cycles for window code 0, 1, 2 or 3, where BASE = CLK_KHZ × 1024 / 1000. After reset, or after a control write that changes the register, the result changes exactly one window length later.
- R6: Edges on the input that is not selected have no effect on the result.
- R7: With bit 1 = 1 each rising edge of the selected input counts once. With bit 1 = 0 each falling edge counts once. Edges of the other direction do not count.
- R8: A control write that changes any implemented bit restarts the window with a zero count and leaves the result register unchanged. Edges seen before the write are discarded.
- R9: Each input passes through two synchronising flops. A pulse whose active level and idle level each last at least 3 clock cycles is counted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sense_a | input | 1 | Asynchronous pulse input A |
| sense_b | input | 1 | Asynchronous pulse input B |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address: 0 control, 1 result |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |

## Verification
The hardest state to reach from the ports is saturation. It needs more than 255 qualified edges inside a single window, and that is only possible in the longest window with pulse widths near the 3-cycle minimum. The bench lowers the clock-frequency parameter so the base tick is 256 cycles. It then drives 3-high/3-low trains of 254, 255, 256 and 300 pulses into the 2048-cycle window, and random runs reach the clamp as well. A second hard case is a control change in the middle of a window while pulses are flowing. The bench stops a train a few cycles before the write and checks that the next result counts only the pulses that follow it.

// File: rtl/prm_pkg.sv
package prm_pkg;

    localparam int unsigned REG_W = 8;
    localparam int unsigned SEL_W = 2;
    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_LATCH = 1'b1;

    typedef struct packed {
        logic [SEL_W-1:0] win;
        logic             pol;
        logic             src;
    } ctrl_t;

    // Register image: src at bit 0, pol at bit 1, window code at 4:3 (R2)
    function automatic logic [REG_W-1:0] ctrl_to_bus(ctrl_t c);
        logic [REG_W-1:0] b;
        b      = '0;
        b[0]   = c.src;
        b[1]   = c.pol;
        b[4:3] = c.win;
        return b;
    endfunction

    function automatic ctrl_t bus_to_ctrl(logic [REG_W-1:0] b);
        ctrl_t c;
        c.src = b[0];
        c.pol = b[1];
        c.win = b[4:3];
        return c;
    endfunction

endpackage

// File: rtl/prm_edge_sync.sv
module prm_edge_sync #(
    parameter int unsigned NUM_IN = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] pin_async,
    output logic [NUM_IN-1:0] rise,
    output logic [NUM_IN-1:0] fall
);
    // STAGES synchroniser flops plus one history flop per input (R9)
    localparam int unsigned CHAIN = STAGES + 1;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        logic [CHAIN-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CHAIN-2:0], pin_async[i]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign rise[i] =  chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
        assign fall[i] = ~chain_q[CHAIN-2] &  chain_q[CHAIN-1];
    end

endmodule

// File: rtl/prm_window_timer.sv
module prm_window_timer #(
    parameter int unsigned BASE_CYCLES = 32768,
    parameter int unsigned SEL_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] win_sel,
    output logic             win_end
);
    localparam int unsigned PRE_W     = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;
    localparam int unsigned MAX_TICKS = 1 << ((1 << SEL_W) - 1);
    localparam int unsigned TICK_W    = $clog2(MAX_TICKS);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(BASE_CYCLES - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [TICK_W-1:0] ticks;
    } tmr_state_t;

    tmr_state_t        s_d, s_q;
    logic [TICK_W-1:0] tick_last;
    logic              base_tick;

    // Window = 2^win_sel base ticks (R5); restart zeroes both stages (R8)
    always_comb begin
        tick_last = TICK_W'((32'd1 << win_sel) - 32'd1);
        base_tick = (s_q.pre == PRE_LAST);
        win_end   = base_tick && (s_q.ticks == tick_last);
        s_d       = s_q;
        if (restart) begin
            s_d = '0;
        end else if (base_tick) begin
            s_d.pre   = '0;
            s_d.ticks = win_end ? '0 : s_q.ticks + TICK_W'(1);
        end else begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/prm_sat_counter.sv
module prm_sat_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             win_end,
    input  logic             edge_hit,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] latch
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] latch;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic [CNT_W-1:0] bumped;

    always_comb begin
        // Clamp at all-ones instead of wrapping (R3)
        bumped = (&s_q.count) ? s_q.count : s_q.count + CNT_W'(edge_hit);
        s_d    = s_q;
        if (restart) begin
            s_d.count = '0;              // result kept (R8)
        end else if (win_end) begin
            s_d.latch = bumped;          // R4
            s_d.count = '0;
        end else begin
            s_d.count = bumped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.count;
    assign latch = s_q.latch;

endmodule

// File: rtl/pulse_rate_meter.sv
module pulse_rate_meter #(
    parameter int unsigned CLK_KHZ     = 32000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sense_a,
    input  logic       sense_b,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    import prm_pkg::*;

    localparam int unsigned NUM_SRC     = 2;
    localparam int unsigned BASE_CYCLES = (CLK_KHZ * 1024) / 1000;

    typedef struct packed {
        ctrl_t ctrl;
    } top_state_t;

    top_state_t         s_d, s_q;
    ctrl_t              wr_ctrl;
    logic               ctrl_wr;
    logic               restart;
    logic               edge_hit;
    logic               win_end;
    logic [NUM_SRC-1:0] rise, fall;
    logic [REG_W-1:0]   cnt_now, latch_val;

    prm_edge_sync #(.NUM_IN(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async({sense_b, sense_a}),
        .rise     (rise),
        .fall     (fall)
    );

    prm_window_timer #(.BASE_CYCLES(BASE_CYCLES), .SEL_W(SEL_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .win_sel(s_q.ctrl.win),
        .win_end(win_end)
    );

    prm_sat_counter #(.CNT_W(REG_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .win_end (win_end),
        .edge_hit(edge_hit),
        .count   (cnt_now),
        .latch   (latch_val)
    );

    always_comb begin
        wr_ctrl  = bus_to_ctrl(wdata);
        ctrl_wr  = wr_en && (addr == ADDR_CTRL);
        restart  = ctrl_wr && (wr_ctrl != s_q.ctrl);       // R8
        s_d      = s_q;
        if (ctrl_wr) s_d.ctrl = wr_ctrl;
        // Source select (R6) and polarity select (R7)
        edge_hit = s_q.ctrl.pol ? rise[s_q.ctrl.src] : fall[s_q.ctrl.src];
        rdata    = (addr == ADDR_LATCH) ? latch_val : ctrl_to_bus(s_q.ctrl);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;                              // R1
        else        s_q <= s_d;
    end

endmodule

// File: rtl/prm_checker.sv
module prm_checker #(
    parameter int unsigned BASE_CYCLES = 32768
) (
    input logic       clk,
    input logic       rst_n,
    input logic       addr,
    input logic [7:0] rdata,
    input logic       restart,
    input logic       win_end,
    input logic [7:0] count,
    input logic [7:0] latch,
    input logic [1:0] win_sel
);
    logic [31:0] gap_q;
    logic [31:0] span_last;

    assign span_last = (32'(BASE_CYCLES) << win_sel) - 32'd1;

    always_ff @(posedge clk) begin
        if (!rst_n || restart || win_end) gap_q <= '0;
        else                              gap_q <= gap_q + 32'd1;
    end

    p_ctrl_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 1'b0) |-> (rdata[7:5] == 3'b000 && rdata[2] == 1'b0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == 8'hFF && !win_end && !restart) |=> (count == 8'hFF));

    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(latch));

    p_count_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (count == 8'h00));

    p_window_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> (gap_q == span_last));

    p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_end && !restart) |=>
            (count == $past(count) || count == $past(count) + 8'd1));

    p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == 8'h00 && $stable(latch)));

endmodule

bind pulse_rate_meter prm_checker #(.BASE_CYCLES(BASE_CYCLES)) u_prm_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .rdata  (rdata),
    .restart(restart),
    .win_end(win_end),
    .count  (cnt_now),
    .latch  (latch_val),
    .win_sel(s_q.ctrl.win)
);

// File: tb/tb_pulse_rate_meter.sv
module tb_pulse_rate_meter;

    localparam int unsigned CLK_KHZ = 250;   // base tick = 256 cycles
    localparam int BASE = (CLK_KHZ * 1024) / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sense_a = 1'b0;
    logic       sense_b = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    bit         cur_src = 1'b0;
    bit         cur_pol = 1'b0;
    int         cur_win = 0;
    logic [7:0] last_exp = 8'h00;

    pulse_rate_meter #(.CLK_KHZ(CLK_KHZ)) dut (
        .clk(clk), .rst_n(rst_n), .sense_a(sense_a), .sense_b(sense_b),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] sat8(int n);
        return (n > 255) ? 8'hFF : 8'(n);
    endfunction

    function automatic int win_len(int code);
        return BASE << code;
    endfunction

    function automatic logic [7:0] cur_bus();
        return {3'b000, 2'(cur_win), 1'b0, cur_pol, cur_src};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%02h exp=%02h", req, what, act, exp);
        end
    endtask

    function automatic logic sel_level();
        return cur_src ? sense_b : sense_a;
    endfunction

    task automatic drive(logic v, bit noise);
        if (cur_src) begin
            sense_b = v;
            if (noise) sense_a = 1'($urandom % 2);
        end else begin
            sense_a = v;
            if (noise) sense_b = 1'($urandom % 2);
        end
    endtask

    // Runs one whole window from its offset 0 and checks the result at its end.
    task automatic run_window(int wlen, int n, int hi, int lo, bit step, bit noise, string req);
        int   per = hi + lo;
        int   edges = 0;
        logic idle, v, prev;
        idle = sel_level();
        prev = idle;
        for (int k = 0; k < wlen; k++) begin
            if (k >= 2 && k < 2 + n * per) v = (((k - 2) % per) < hi) ? ~idle : idle;
            else if (step && k >= 2 + n * per) v = ~idle;
            else v = idle;
            drive(v, noise && (k < wlen - 8));
            if (v != prev && v == cur_pol) edges++;
            prev = v;
            if (k == wlen - 1) check(req, rdata, last_exp, "result held until window end (R4 R5)");
            @(negedge clk);
        end
        last_exp = sat8(edges);
        check(req, rdata, last_exp, "result latched at window end");
    endtask

    task automatic write_ctrl(logic [7:0] v);
        wdata = v;
        addr  = 1'b0;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = 1'b1;
        cur_src = v[0];
        cur_pol = v[1];
        cur_win = int'(v[4:3]);
        #1;
        check("R8", rdata, last_exp, "result unchanged by control write");
    endtask

    task automatic read_ctrl(logic [7:0] exp, string req);
        addr = 1'b0;
        #1;
        check(req, rdata, exp, "control readback");
        addr = 1'b1;
        #1;
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (5) @(negedge clk);
        // R1: reset values
        addr = 1'b0; #1;
        check("R1", rdata, 8'h00, "control after reset");
        addr = 1'b1; #1;
        check("R1", rdata, 8'h00, "result after reset");
        rst_n = 1'b1;   // at a negedge: offset 0 of the first window

        // R4 R6 R9: 3-cycle pulses on A, noise on B, falling edges
        run_window(win_len(0), 20, 3, 3, 1'b0, 1'b1, "R6");
        run_window(win_len(0), 0, 3, 3, 1'b0, 1'b1, "R4");

        // R2: unused bits ignored; B, rising, longest window
        write_ctrl(8'hFF);
        read_ctrl(8'h1B, "R2");
        // R3: saturation boundaries
        run_window(win_len(3), 254, 3, 3, 1'b0, 1'b1, "R3");
        run_window(win_len(3), 255, 3, 3, 1'b0, 1'b1, "R3");
        run_window(win_len(3), 256, 3, 3, 1'b0, 1'b1, "R3");
        run_window(win_len(3), 300, 3, 3, 1'b0, 1'b1, "R3");
        run_window(win_len(3), 5, 3, 3, 1'b0, 1'b0, "R4");

        // R7: single steps under each polarity, input A
        write_ctrl(8'h02);
        read_ctrl(8'h02, "R2");
        run_window(win_len(0), 0, 3, 3, 1'b1, 1'b0, "R7");
        run_window(win_len(0), 0, 3, 3, 1'b1, 1'b0, "R7");
        write_ctrl(8'h00);
        run_window(win_len(0), 0, 3, 3, 1'b1, 1'b0, "R7");
        run_window(win_len(0), 0, 3, 3, 1'b1, 1'b0, "R7");

        // R5: middle window codes
        write_ctrl(8'h08);
        run_window(win_len(1), 40, 4, 5, 1'b0, 1'b1, "R5");
        write_ctrl(8'h10);
        run_window(win_len(2), 100, 3, 4, 1'b0, 1'b1, "R5");

        // R8: pulses then a mid-window control change
        for (int k = 0; k < 80; k++) begin
            drive((k >= 2 && k < 62 && ((k - 2) % 6) < 3) ? ~sel_level() : sel_level(), 1'b0);
            if (k >= 2 && k < 62 && ((k - 2) % 6) == 3) drive(~sel_level(), 1'b0);
            @(negedge clk);
        end
        write_ctrl(8'h11);
        run_window(win_len(2), 7, 3, 3, 1'b0, 1'b0, "R8");

        // Random configurations and trains
        for (int it = 0; it < 6; it++) begin
            logic [7:0] v;
            int hi, lo, per, maxn, n, wl;
            bit stp;
            v = 8'($urandom) & 8'h1B;
            if (v == cur_bus()) v = v ^ 8'h01;
            write_ctrl(v);
            read_ctrl(v, "R2");
            wl   = win_len(cur_win);
            hi   = 3 + int'($urandom % 4);
            lo   = 3 + int'($urandom % 4);
            per  = hi + lo;
            maxn = (wl - 12) / per;
            n    = ($urandom % 3 == 0) ? maxn : int'($urandom % (maxn + 1));
            stp  = 1'($urandom % 2);
            run_window(wl, n, hi, lo, stp, 1'b1, "R9");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule